// File: doc/BRIEF.md
# Receive Event Interrupt Vector Generator

This block sits on the receive side of a multichannel HDLC/PPP serial controller. It turns receive-side events into 32-bit interrupt vectors for the host. The events come from several places: a time-multiplexed bit stream, packet delimiters, descriptor completion, per-channel descriptor hold levels and a CPU abort command. Each vector names the channel and that channel's queue number. It also sets one or two of four event flags: host-initiated, abort, frame end and hold abort.

An abort detector counts consecutive ones on each channel. The limit depends on that channel's protocol mode: more than 6 ones in HDLC and more than 15 in PPP. Per-channel hold state follows discards while a descriptor is held. The first packet dropped during a hold reports as a plain hold abort. Each further drop reports abort and hold abort together, which marks a silent discard. Vectors wait in a small FIFO with a valid/ready output. If a vector cannot be stored, it is dropped and a sticky flag records the loss.

Top module: `rxv_irq_gen`

## Requirements
- R1: Vector layout: bits 7:0 hold the channel, bits 10:8 hold that channel's 3-bit field of `chan_queue` (channel c uses bits 3c+2:3c), bit 31 is host-initiated, bit 30 is abort, bit 29 is frame end, bit 28 is hold abort, and every other bit is zero. After reset, `vec_valid` and `ovf_flag` are low.
- R2: On a channel whose `proto_ppp` bit is 0 (HDLC), the 7th consecutive one strobed for that channel queues one vector with only the abort flag.
- R3: On a channel whose `proto_ppp` bit is 1 (PPP), the 16th consecutive one queues one abort vector, and the 7th does not.
- R4: A strobed zero restarts the channel's count of ones. The count saturates, so a run of ones of any length yields only one abort vector until the next zero.
- R5: A `cpu_abort` pulse queues an abort vector for `abort_chan`.
- R6: A `pkt_end` pulse, which marks a frame fully stored, queues a frame-end vector for `end_chan`.
- R7: A `desc_done` pulse with `desc_hi`=1 queues a host-initiated vector for `desc_chan`. With `desc_hi`=0, no vector is queued.
- R8: A `pkt_start` on a channel whose `desc_hold` bit is 1 queues a hold-abort-only vector for the first such packet. A `pkt_start` on a channel that is not held queues nothing.
- R9: Each further `pkt_start` on that channel, while its hold stays set, queues a vector with both abort and hold abort set.
- R10: Clearing a channel's `desc_hold` for at least one cycle resets its discard state, so the next discard again reports as hold-abort only.
- R11: Vectors leave in arrival order. A vector is removed only in a cycle where `vec_valid` and `vec_ready` are both high, and it holds steady while it waits.
- R12: When DEPTH vectors are stored and none leaves in that cycle, a new vector is dropped, the stored ones are kept, and `ovf_flag` goes high and stays high until reset.
- R13: When several events arrive in one cycle, only the highest-priority one is queued. The order is ones-run abort, CPU abort, hold discard, frame end, then host-initiated. The others are lost, and `ovf_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proto_ppp | input | NCH | Per-channel mode: 1 = PPP, 0 = HDLC |
| chan_queue | input | 3*NCH | Per-channel queue number, 3 bits each |
| bit_vld | input | 1 | Received-bit strobe |
| bit_chan | input | CW | Channel of the strobed bit |
| bit_val | input | 1 | Value of the strobed bit |
| pkt_start | input | 1 | A new packet begins |
| pkt_chan | input | CW | Channel of the new packet |
| pkt_end | input | 1 | A frame is fully stored |
| end_chan | input | CW | Channel of the stored frame |
| desc_done | input | 1 | Descriptor processing finished |
| desc_chan | input | CW | Channel of the finished descriptor |
| desc_hi | input | 1 | Host-interrupt bit of the finished descriptor |
| desc_hold | input | NCH | Per-channel hold bit of the current descriptor |
| cpu_abort | input | 1 | CPU receive abort command |
| abort_chan | input | CW | Channel of the abort command |
| vec_valid | output | 1 | A vector is available |
| vec_ready | input | 1 | Host takes the vector |
| vec_data | output | 32 | Interrupt vector |
| ovf_flag | output | 1 | Sticky: a vector was lost |

## Verification
A wrong count of ones shows up at the ports as an abort vector one strobe too early or too late, or as extra abort vectors on a long idle run. The error appears on the cycle after the strobe in question. Hold-state errors show up as wrong flags on the second or third discard vector, or on the first discard after a release. Any mismatch in the queue's contents or in the sticky flag shows up at the next cycle's comparison against a behavioural model of the queue and counters.

// File: rtl/rxv_pkg.sv
// Shared constants and vector packing for the receive interrupt vector generator.
// Assumes channel numbers fit in 8 bits and queue numbers in 3 bits.
package rxv_pkg;
    localparam int VEC_W  = 32;
    localparam int FLAG_W = 4;
    // Flag nibble, MSB first: host-initiated, abort, frame end, hold abort
    localparam logic [FLAG_W-1:0] FL_HI   = 4'b1000;
    localparam logic [FLAG_W-1:0] FL_ABT  = 4'b0100;
    localparam logic [FLAG_W-1:0] FL_FE   = 4'b0010;
    localparam logic [FLAG_W-1:0] FL_HABT = 4'b0001;

    // Pack flags, queue and channel into one vector; unused bits are zero
    function automatic logic [VEC_W-1:0] mk_vec(input logic [FLAG_W-1:0] f,
                                                input logic [2:0] q,
                                                input logic [7:0] ch);
        return {f, 17'd0, q, ch};
    endfunction
endpackage

// File: rtl/rxv_ones_det.sv
// Per-channel consecutive-ones abort detector.
// Counts ones strobed for each channel, restarts on a zero, and flags the
// strobe that makes the run exceed the mode limit (6 HDLC, 15 PPP).
// The count saturates one above the limit so a long run flags once.
// Assumes at most one strobe per cycle and bit_chan < NCH.
module rxv_ones_det #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] proto_ppp,
    input  logic           bit_vld,
    input  logic [CW-1:0]  bit_chan,
    input  logic           bit_val,
    output logic           abort_hit,
    output logic [CW-1:0]  abort_ch
);
    localparam int RUN_W = 5;
    localparam logic [RUN_W-1:0] LIM_HDLC = 5'd6;
    localparam logic [RUN_W-1:0] LIM_PPP  = 5'd15;

    logic [NCH-1:0] hit;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] lim;
        logic             mine;

        // Select the channel's limit and decode its strobe
        always_comb begin
            lim  = proto_ppp[g] ? LIM_PPP : LIM_HDLC;
            mine = bit_vld && (bit_chan == CW'(g));
        end

        // Run counter: clear on zero, count ones up to limit+1
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run <= '0;
            end else if (mine) begin
                if (!bit_val)        run <= '0;
                else if (run <= lim) run <= run + 1'b1;
            end
        end

        assign hit[g] = mine && bit_val && (run == lim);
    end

    // Only the strobed channel can hit, so its number is the source
    assign abort_hit = |hit;
    assign abort_ch  = bit_chan;
endmodule

// File: rtl/rxv_hold_track.sv
// Per-channel discard tracker for held descriptors.
// A packet start on a held channel is a discard; the first one after the hold
// is seen reports plain, later ones report silent. Releasing the hold clears it.
// Assumes pkt_chan < NCH.
module rxv_hold_track #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] desc_hold,
    input  logic           pkt_start,
    input  logic [CW-1:0]  pkt_chan,
    output logic           disc_vld,
    output logic           disc_silent
);
    logic [NCH-1:0] seen;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Remember a discard until the hold bit drops
        always_ff @(posedge clk) begin
            if (!rst_n)                                 seen[g] <= 1'b0;
            else if (!desc_hold[g])                     seen[g] <= 1'b0;
            else if (pkt_start && pkt_chan == CW'(g))   seen[g] <= 1'b1;
        end
    end

    assign disc_vld    = pkt_start && desc_hold[pkt_chan];
    assign disc_silent = seen[pkt_chan];
endmodule

// File: rtl/rxv_vec_fifo.sv
// Show-ahead vector FIFO. A push while full is refused unless a pop happens
// in the same cycle. Assumes DEPTH is a power of two.
module rxv_vec_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/rxv_irq_gen.sv
// Receive event interrupt vector generator (top).
// Gathers five event sources, picks one per cycle by fixed priority, builds
// the 32-bit vector and queues it. Lost vectors (collision or full queue)
// set a sticky flag. Assumes NCH <= 128 and all channel inputs < NCH.
module rxv_irq_gen #(
    parameter int NCH   = 4,
    parameter int DEPTH = 4,
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   proto_ppp,
    input  logic [3*NCH-1:0] chan_queue,
    input  logic             bit_vld,
    input  logic [CW-1:0]    bit_chan,
    input  logic             bit_val,
    input  logic             pkt_start,
    input  logic [CW-1:0]    pkt_chan,
    input  logic             pkt_end,
    input  logic [CW-1:0]    end_chan,
    input  logic             desc_done,
    input  logic [CW-1:0]    desc_chan,
    input  logic             desc_hi,
    input  logic [NCH-1:0]   desc_hold,
    input  logic             cpu_abort,
    input  logic [CW-1:0]    abort_chan,
    output logic             vec_valid,
    input  logic             vec_ready,
    output logic [31:0]      vec_data,
    output logic             ovf_flag
);
    import rxv_pkg::*;

    localparam int NSRC = 5;

    logic              run_hit, disc_vld, disc_silent;
    logic [CW-1:0]     run_ch;
    logic [NSRC-1:0]   req;
    logic [FLAG_W-1:0] flg [NSRC];
    logic [CW-1:0]     sch [NSRC];
    logic [FLAG_W-1:0] sel_flg;
    logic [CW-1:0]     sel_ch;
    logic [2:0]        sel_q;
    logic [VEC_W-1:0]  new_vec;
    logic              any_evt, collide, q_full, q_empty;

    rxv_ones_det #(.NCH(NCH), .CW(CW)) u_ones (
        .clk, .rst_n, .proto_ppp, .bit_vld, .bit_chan, .bit_val,
        .abort_hit(run_hit), .abort_ch(run_ch)
    );

    rxv_hold_track #(.NCH(NCH), .CW(CW)) u_hold (
        .clk, .rst_n, .desc_hold, .pkt_start, .pkt_chan,
        .disc_vld, .disc_silent
    );

    // Event sources in priority order, index 0 highest
    always_comb begin
        req[0] = run_hit;            flg[0] = FL_ABT;  sch[0] = run_ch;
        req[1] = cpu_abort;          flg[1] = FL_ABT;  sch[1] = abort_chan;
        req[2] = disc_vld;
        flg[2] = disc_silent ? (FL_ABT | FL_HABT) : FL_HABT;
        sch[2] = pkt_chan;
        req[3] = pkt_end;            flg[3] = FL_FE;   sch[3] = end_chan;
        req[4] = desc_done && desc_hi; flg[4] = FL_HI; sch[4] = desc_chan;
    end

    // Fixed-priority pick of the winning event
    always_comb begin
        sel_flg = '0;
        sel_ch  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel_flg = flg[i];
                sel_ch  = sch[i];
            end
        end
    end

    assign any_evt = |req;
    assign collide = ($countones(req) > 1);
    assign sel_q   = chan_queue[int'(sel_ch)*3 +: 3];
    assign new_vec = mk_vec(sel_flg, sel_q, {{(8-CW){1'b0}}, sel_ch});

    rxv_vec_fifo #(.DEPTH(DEPTH), .W(VEC_W)) u_fifo (
        .clk, .rst_n, .push(any_evt), .din(new_vec), .pop(vec_ready),
        .full(q_full), .empty(q_empty), .dout(vec_data)
    );

    assign vec_valid = !q_empty;

    // Sticky loss flag: collision or push refused by a full queue
    always_ff @(posedge clk) begin
        if (!rst_n)                                      ovf_flag <= 1'b0;
        else if (collide || (any_evt && q_full && !vec_ready)) ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/rxv_irq_chk.sv
// Port-level protocol checks for rxv_irq_gen, bound to every instance.
module rxv_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vec_valid,
    input logic        vec_ready,
    input logic [31:0] vec_data,
    input logic        ovf_flag,
    input logic        pkt_end,
    input logic        cpu_abort
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!vec_valid && !ovf_flag));

    // R1
    zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_data[27:11] == 17'd0 && vec_data[31:28] != 4'd0));

    // R11
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)));

    // R12
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R6
    fe_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> vec_valid);

    // R5
    cpu_abt_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_abort |=> vec_valid);
endmodule

bind rxv_irq_gen rxv_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .ovf_flag(ovf_flag), .pkt_end(pkt_end),
    .cpu_abort(cpu_abort)
);

// File: tb/rxv_irq_gen_tb.sv
// Bench for rxv_irq_gen: directed and random stimulus, checked every cycle
// against a behavioural model built from the requirements.
module rxv_irq_gen_tb;
    localparam int NCH   = 4;
    localparam int DEPTH = 4;
    localparam int CW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   proto_ppp = 4'b0010;
    logic [3*NCH-1:0] chan_queue = {3'd7, 3'd5, 3'd3, 3'd1};
    logic             bit_vld = 0, bit_val = 0, pkt_start = 0, pkt_end = 0;
    logic             desc_done = 0, desc_hi = 0, cpu_abort = 0, vec_ready = 0;
    logic [CW-1:0]    bit_chan = 0, pkt_chan = 0, end_chan = 0, desc_chan = 0, abort_chan = 0;
    logic [NCH-1:0]   desc_hold = '0;
    logic             vec_valid, ovf_flag;
    logic [31:0]      vec_data;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit cmp_en = 0;

    always #4 clk = ~clk;

    rxv_irq_gen #(.NCH(NCH), .DEPTH(DEPTH)) u_dut (.*);

    // ---------------- behavioural model ----------------
    int          m_run [NCH];
    bit          m_seen [NCH];
    logic [31:0] m_q [$];
    logic [31:0] m_cand [$];
    bit          m_ovf;

    function automatic logic [31:0] vec_of(logic [3:0] f, int ch);
        return {f, 17'd0, chan_queue[ch*3 +: 3], 8'(ch)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_ovf = 0;
            foreach (m_run[i]) begin m_run[i] = 0; m_seen[i] = 0; end
        end else begin
            automatic bit pop = (m_q.size() > 0) && vec_ready;
            automatic int lim = proto_ppp[bit_chan] ? 15 : 6;
            m_cand.delete();
            if (bit_vld && bit_val && m_run[bit_chan] == lim) m_cand.push_back(vec_of(4'b0100, int'(bit_chan)));
            if (cpu_abort) m_cand.push_back(vec_of(4'b0100, int'(abort_chan)));
            if (pkt_start && desc_hold[pkt_chan])
                m_cand.push_back(vec_of(m_seen[pkt_chan] ? 4'b0101 : 4'b0001, int'(pkt_chan)));
            if (pkt_end) m_cand.push_back(vec_of(4'b0010, int'(end_chan)));
            if (desc_done && desc_hi) m_cand.push_back(vec_of(4'b1000, int'(desc_chan)));
            if (bit_vld) begin
                if (!bit_val) m_run[bit_chan] = 0;
                else if (m_run[bit_chan] <= lim) m_run[bit_chan]++;
            end
            for (int c = 0; c < NCH; c++) begin
                if (!desc_hold[c]) m_seen[c] = 0;
                else if (pkt_start && int'(pkt_chan) == c) m_seen[c] = 1;
            end
            if (pop) void'(m_q.pop_front());
            if (m_cand.size() > 1) m_ovf = 1;
            if (m_cand.size() > 0) begin
                if (m_q.size() < DEPTH) m_q.push_back(m_cand[0]);
                else m_ovf = 1;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            automatic bit ev = (m_q.size() > 0);
            automatic logic [31:0] ed = ev ? m_q[0] : 32'd0;
            checks++;
            if (vec_valid !== ev || ovf_flag !== m_ovf || (ev && vec_data !== ed)) begin
                fails++;
                $display("FAIL %s: valid=%0b data=%h ovf=%0b expected valid=%0b data=%h ovf=%0b",
                         cur_req, vec_valid, vec_data, ovf_flag, ev, ed, m_ovf);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        bit_vld = 0; bit_val = 0; pkt_start = 0; pkt_end = 0;
        desc_done = 0; desc_hi = 0; cpu_abort = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
    endtask

    task automatic bits(int ch, int n, bit v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); clr();
            bit_vld = 1; bit_chan = CW'(ch); bit_val = v;
        end
    endtask

    task automatic pstart(int ch);
        @(negedge clk); clr(); pkt_start = 1; pkt_chan = CW'(ch);
    endtask

    task automatic do_reset();
        @(negedge clk); clr(); rst_n = 0; desc_hold = '0; vec_ready = 0;
        idle(2); rst_n = 1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        cmp_en = 1;
        idle(1);
        // R1: reset state
        chk(!vec_valid && !ovf_flag, "R1", {30'd0, vec_valid, ovf_flag}, 32'd0);

        // R2: HDLC abort on the 7th one, exact vector value
        cur_req = "R2";
        bits(2, 7, 1); idle(1);
        chk(vec_valid && vec_data == 32'h4000_0502, "R2", vec_data, 32'h4000_0502);
        bits(2, 9, 1);                      // R4: saturated run, no second vector
        vec_ready = 1; idle(3);
        chk(!vec_valid, "R4", {31'd0, vec_valid}, 32'd0);

        // R4: zero restarts the count
        cur_req = "R4";
        bits(0, 6, 1); bits(0, 1, 0); bits(0, 6, 1); idle(2);
        chk(!vec_valid, "R4", {31'd0, vec_valid}, 32'd0);
        bits(0, 1, 0);

        // R3: PPP channel needs 16 ones
        cur_req = "R3";
        vec_ready = 0;
        bits(1, 7, 1); idle(1);
        chk(!vec_valid, "R3", {31'd0, vec_valid}, 32'd0);
        bits(1, 9, 1); idle(1);
        chk(vec_valid && vec_data == 32'h4000_0301, "R3", vec_data, 32'h4000_0301);
        vec_ready = 1; idle(2);

        // R5 CPU abort, R6 frame end, R7 host-initiated
        cur_req = "R5";
        @(negedge clk); clr(); cpu_abort = 1; abort_chan = 3;
        idle(1);
        chk(vec_valid && vec_data == 32'h4000_0703, "R5", vec_data, 32'h4000_0703);
        cur_req = "R6";
        @(negedge clk); clr(); pkt_end = 1; end_chan = 0;
        idle(1);
        chk(vec_valid && vec_data == 32'h2000_0100, "R6", vec_data, 32'h2000_0100);
        cur_req = "R7";
        @(negedge clk); clr(); desc_done = 1; desc_hi = 0; desc_chan = 2;
        idle(2);
        chk(!vec_valid, "R7", {31'd0, vec_valid}, 32'd0);
        @(negedge clk); clr(); desc_done = 1; desc_hi = 1; desc_chan = 2;
        idle(1);
        chk(vec_valid && vec_data == 32'h8000_0502, "R7", vec_data, 32'h8000_0502);
        idle(2);

        // R8/R9/R10: hold discards
        cur_req = "R8";
        pstart(1); idle(2);                 // not held: nothing
        chk(!vec_valid, "R8", {31'd0, vec_valid}, 32'd0);
        vec_ready = 0; desc_hold[1] = 1;
        pstart(1); idle(1);
        chk(vec_valid && vec_data == 32'h1000_0301, "R8", vec_data, 32'h1000_0301);
        cur_req = "R9";
        vec_ready = 1; idle(1); vec_ready = 0;
        pstart(1); idle(1);
        chk(vec_valid && vec_data == 32'h5000_0301, "R9", vec_data, 32'h5000_0301);
        pstart(1); vec_ready = 1; idle(3);
        cur_req = "R10";
        vec_ready = 0; desc_hold[1] = 0; idle(1); desc_hold[1] = 1;
        pstart(1); idle(1);
        chk(vec_valid && vec_data == 32'h1000_0301, "R10", vec_data, 32'h1000_0301);
        vec_ready = 1; idle(2); desc_hold = '0;

        // R11: ordering under back-pressure
        cur_req = "R11";
        vec_ready = 0;
        @(negedge clk); clr(); pkt_end = 1; end_chan = 3;
        @(negedge clk); clr(); cpu_abort = 1; abort_chan = 0;
        idle(4);
        chk(vec_data == 32'h2000_0703, "R11", vec_data, 32'h2000_0703);
        vec_ready = 1; idle(1); vec_ready = 0;
        chk(vec_data == 32'h4000_0100, "R11", vec_data, 32'h4000_0100);
        vec_ready = 1; idle(2);

        // R13: collision keeps the highest priority, sets the flag
        cur_req = "R13";
        vec_ready = 0;
        @(negedge clk); clr();
        cpu_abort = 1; abort_chan = 0; pkt_end = 1; end_chan = 3;
        desc_done = 1; desc_hi = 1; desc_chan = 2;
        idle(1);
        chk(vec_valid && ovf_flag && vec_data == 32'h4000_0100, "R13", vec_data, 32'h4000_0100);
        vec_ready = 1; idle(2);

        // R12: full queue drops the newest
        cur_req = "R1";
        do_reset();
        idle(1);
        chk(!ovf_flag, "R1", {31'd0, ovf_flag}, 32'd0);
        cur_req = "R12";
        for (int i = 0; i < DEPTH + 1; i++) begin
            @(negedge clk); clr(); pkt_end = 1; end_chan = CW'(i % NCH);
        end
        idle(1);
        chk(ovf_flag && vec_data == 32'h2000_0100, "R12", vec_data, 32'h2000_0100);
        vec_ready = 1; idle(6);
        chk(!vec_valid && ovf_flag, "R12", {30'd0, vec_valid, ovf_flag}, 32'd1);

        // Random mix, checked every cycle by the model (R2..R13)
        cur_req = "R4";
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); clr();
            cur_req = (i % 2 == 0) ? "R9" : "R11";
            vec_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 1) == 1) begin
                bit_vld = 1; bit_chan = CW'($urandom_range(0, NCH-1));
                bit_val = ($urandom_range(0, 9) != 0);
            end
            if ($urandom_range(0, 15) == 0) begin pkt_start = 1; pkt_chan = CW'($urandom_range(0, NCH-1)); end
            if ($urandom_range(0, 19) == 0) begin pkt_end = 1; end_chan = CW'($urandom_range(0, NCH-1)); end
            if ($urandom_range(0, 19) == 0) begin
                desc_done = 1; desc_hi = 1'($urandom_range(0, 1)); desc_chan = CW'($urandom_range(0, NCH-1));
            end
            if ($urandom_range(0, 39) == 0) begin cpu_abort = 1; abort_chan = CW'($urandom_range(0, NCH-1)); end
            if ($urandom_range(0, 29) == 0) desc_hold = 4'($urandom_range(0, 15));
            if (i == 1500) begin proto_ppp = 4'b1001; end
        end
        idle(10);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule